// File: doc/BRIEF.md
# Transport-Triggered Move Processor Core

This core executes programs built from one kind of instruction: a move that copies a value from a source port to a destination port over a shared transport bus. There is no opcode field. An operation starts only because data lands in a functional unit's trigger input. A program therefore computes a sum by moving the first operand into the adder's first input, moving the second operand into its trigger input, and later moving the adder's result out to wherever it is needed.

Ports are addressed by socket number. General-purpose registers and the functional units' inputs and outputs all share one address space. A new unit is added by giving it three more addresses, and the instruction format, the fetch logic and the bus stay the same. A testbench or host fills the instruction memory through a write port and then raises `run`. The core performs one move per clock until a move targets the halt address. Any port can then be read back through a side read port.

Top module: `move_core`

## Requirements
- R1: While reset is asserted and right after it, `done` is 0, the program counter is 0, and every general-purpose register and every functional-unit output reads 0.
- R2: An instruction word holds the source address in bits 15:8 and the destination address in bits 7:0. A move between general-purpose registers 0x00–0x0F copies the source value into the destination and leaves the source unchanged.
- R3: Source address 0xF0 takes the moved value from the next instruction word, and the program counter then advances by 2, so that word is never executed as an instruction.
- R4: A move into a first input (adder 0x10, subtractor 0x13) only latches the operand. The unit's output does not change.
- R5: A move into the adder's trigger input 0x11 latches the operand and computes first-input plus trigger-operand modulo 2^16. The result is readable at 0x12 from the second move after the trigger onward.
- R6: The subtractor at 0x13 (first input), 0x14 (trigger) and 0x15 (output) produces first-input minus trigger-operand modulo 2^16, with the same timing as the adder.
- R7: A move that reads an output in the instruction directly after that unit's trigger returns the previous result.
- R8: A move whose destination is an output-only port (0x12, 0x15) has no effect on that port.
- R9: Reading any address that is not a general-purpose register or a unit output returns 0. This includes the write-only inputs 0x10, 0x11, 0x13, 0x14 and unmapped addresses such as 0x40.
- R10: A move to destination 0xFF stops fetching and sets `done`. `done` stays set until reset, and no later instruction takes effect.
- R11: While `run` is 0, no instruction executes and the program counter holds.
- R12: Exactly one move completes per clock cycle while running, an immediate move included. A program of N moves followed by a halt raises `done` after N+1 clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables instruction fetch and execution |
| imem_we | input | 1 | Instruction memory write enable |
| imem_addr | input | 6 | Instruction memory write address |
| imem_wdata | input | 16 | Instruction word to write |
| dbg_port | input | 8 | Port address for side readback |
| dbg_data | output | 16 | Value of the port named by `dbg_port` (0 if unreadable) |
| done | output | 1 | Set once a halt move has executed |

## Verification
The hardest case to reach is the one-move gap between a trigger and its result. It only shows up when an output is read in the slot right after a trigger while that output still holds an earlier, distinguishable result. The bench therefore computes a first sum, waits one move, triggers a second sum with different operands, and reads the output in two back-to-back moves: the first move must return the old sum and the second the new one. Immediate words are chosen so that a wrong program-counter step would decode them as a halt and make the error visible.

// File: rtl/move_core.sv
module move_core #(
  parameter int DW         = 16,
  parameter int AW         = 8,
  parameter int IMEM_DEPTH = 64,
  parameter int NGPR       = 16,
  parameter int NFU        = 2,
  parameter logic [AW-1:0] FU_BASE  = 8'h10,
  parameter logic [AW-1:0] IMM_SRC  = 8'hF0,
  parameter logic [AW-1:0] HALT_DST = 8'hFF
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run,
  input  logic                          imem_we,
  input  logic [$clog2(IMEM_DEPTH)-1:0] imem_addr,
  input  logic [2*AW-1:0]               imem_wdata,
  input  logic [AW-1:0]                 dbg_port,
  output logic [DW-1:0]                 dbg_data,
  output logic                          done
);
  localparam int PW = $clog2(IMEM_DEPTH);
  localparam int IW = 2 * AW;
  localparam int GW = $clog2(NGPR);

  logic [IW-1:0] imem [IMEM_DEPTH];
  logic [PW-1:0] pc;
  logic [DW-1:0] gpr [NGPR];
  logic [DW-1:0] fu_a [NFU];
  logic [DW-1:0] fu_res [NFU];
  logic [DW-1:0] fu_o [NFU];
  logic [NFU-1:0] fu_go, fu_trig;
  logic [DW-1:0] mv_val;

  wire [IW-1:0] instr  = imem[pc];
  wire [IW-1:0] nxt    = imem[pc + PW'(1)];
  wire [AW-1:0] src    = instr[IW-1:AW];
  wire [AW-1:0] dst    = instr[AW-1:0];
  wire          is_imm = (src == IMM_SRC);
  wire          step   = run && !done;

  function automatic logic [DW-1:0] rd_port(input logic [AW-1:0] p);
    logic [DW-1:0] v;
    v = '0;
    if (p < AW'(NGPR)) v = gpr[p[GW-1:0]];
    for (int i = 0; i < NFU; i++)
      if (p == FU_BASE + AW'(3*i+2)) v = fu_o[i];
    return v;
  endfunction

  function automatic logic [DW-1:0] fu_op(input int i, input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (i % 2 == 0) ? a + b : a - b;
  endfunction

  assign mv_val   = is_imm ? DW'(nxt) : rd_port(src);
  assign dbg_data = rd_port(dbg_port);

  always_comb
    for (int i = 0; i < NFU; i++)
      fu_trig[i] = step && (dst == FU_BASE + AW'(3*i+1));

  always_ff @(posedge clk)
    if (imem_we) imem[imem_addr] <= imem_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pc   <= '0;
      done <= 1'b0;
    end else if (step) begin
      pc <= pc + (is_imm ? PW'(2) : PW'(1));
      if (dst == HALT_DST) done <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NGPR; i++) gpr[i] <= '0;
    end else if (step && dst < AW'(NGPR)) begin
      gpr[dst[GW-1:0]] <= mv_val;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fu_go <= '0;
      for (int i = 0; i < NFU; i++) begin
        fu_a[i]   <= '0;
        fu_res[i] <= '0;
        fu_o[i]   <= '0;
      end
    end else begin
      fu_go <= fu_trig;
      for (int i = 0; i < NFU; i++) begin
        if (step && dst == FU_BASE + AW'(3*i)) fu_a[i] <= mv_val;
        if (fu_trig[i]) fu_res[i] <= fu_op(i, fu_a[i], mv_val);
        if (fu_go[i])   fu_o[i]   <= fu_res[i];
      end
    end
endmodule

// File: rtl/move_core_chk.sv
module move_core_chk #(
  parameter int PW = 6,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          done,
  input logic [PW-1:0] pc,
  input logic          add_trig,
  input logic [DW-1:0] add_o
);
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done |=> done); // R10
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) done |=> $stable(pc)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!run && !done) |=> $stable(pc)); // R11
  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) (run && !done) |=> !$stable(pc)); // R12
  AST_ADD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) !$stable(add_o) |-> $past(add_trig, 2)); // R5
endmodule

bind move_core move_core_chk #(.PW(PW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .done(done), .pc(pc),
  .add_trig(fu_trig[0]), .add_o(fu_o[0])
);

// File: tb/sim_move_core.sv
`timescale 1ns/1ps
module sim_move_core;
  localparam logic [7:0] A_I1 = 8'h10, A_I2 = 8'h11, A_O = 8'h12;
  localparam logic [7:0] S_I1 = 8'h13, S_I2 = 8'h14, S_O = 8'h15;
  localparam logic [7:0] IMM = 8'hF0, HLT = 8'hFF;

  logic clk = 0, rst_n = 0, run = 0, imem_we = 0;
  logic [5:0] imem_addr = '0;
  logic [15:0] imem_wdata = '0;
  logic [7:0] dbg_port = '0;
  logic [15:0] dbg_data;
  logic done;

  int n_chk = 0, n_bad = 0, pidx = 0;
  logic [15:0] prog [64];

  always #2.5 clk = ~clk;

  move_core u0 (.clk(clk), .rst_n(rst_n), .run(run), .imem_we(imem_we),
    .imem_addr(imem_addr), .imem_wdata(imem_wdata), .dbg_port(dbg_port),
    .dbg_data(dbg_data), .done(done));

  function automatic logic [15:0] mv(input logic [7:0] s, input logic [7:0] d);
    return {s, d};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] w);
    prog[pidx] = w;
    pidx++;
  endtask

  task automatic put_imm(input logic [15:0] v, input logic [7:0] d);
    put(mv(IMM, d));
    put(v);
  endtask

  task automatic start_prog();
    pidx = 0;
    for (int i = 0; i < 64; i++) prog[i] = mv(8'h00, HLT);
  endtask

  task automatic load_and_reset();
    @(negedge clk);
    rst_n = 0; run = 0;
    for (int i = 0; i < 64; i++) begin
      imem_we = 1; imem_addr = 6'(i); imem_wdata = prog[i];
      @(negedge clk);
    end
    imem_we = 0;
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic exec(output int cyc);
    run = 1;
    cyc = 0;
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    run = 0;
    if (!done) chk("R10 halt reached", 16'(done), 16'd1);
  endtask

  task automatic rd(input logic [7:0] p, output logic [15:0] v);
    dbg_port = p;
    #0.5;
    v = dbg_data;
  endtask

  task automatic t_move_imm();
    int c; logic [15:0] v;
    start_prog();
    put_imm(16'h05FF, 8'h01);
    put(mv(8'h01, 8'h03));
    put_imm(16'hBEEF, 8'h02);
    put(mv(8'h02, 8'h09));
    load_and_reset();
    exec(c);
    rd(8'h03, v); chk("R3 imm word skipped", v, 16'h05FF);
    rd(8'h01, v); chk("R3 imm value", v, 16'h05FF);
    rd(8'h09, v); chk("R2 dst field low byte", v, 16'hBEEF);
    rd(8'h02, v); chk("R2 source unchanged", v, 16'hBEEF);
  endtask

  task automatic t_adder();
    int c; logic [15:0] v;
    start_prog();
    put_imm(16'd7, A_I1);
    load_and_reset();
    exec(c);
    rd(A_O, v); chk("R4 first input only latches", v, 16'h0000);
    start_prog();
    put_imm(16'd1, A_I1);
    put_imm(16'd2, A_I2);
    put(mv(8'h00, 8'h00));
    put_imm(16'd5, A_I1);
    put_imm(16'd6, A_I2);
    put(mv(A_O, 8'h03));
    put(mv(A_O, 8'h04));
    put_imm(16'hFFF0, A_I1);
    put_imm(16'h0020, A_I2);
    put(mv(8'h00, 8'h00));
    put(mv(A_O, 8'h05));
    load_and_reset();
    exec(c);
    rd(8'h03, v); chk("R7 read right after trigger is old", v, 16'd3);
    rd(8'h04, v); chk("R5 sum", v, 16'd11);
    rd(8'h05, v); chk("R5 sum wraps", v, 16'h0010);
  endtask

  task automatic t_sub();
    int c; logic [15:0] v;
    start_prog();
    put_imm(16'd3, S_I1);
    put_imm(16'd5, S_I2);
    put(mv(8'h00, 8'h00));
    put(mv(S_O, 8'h01));
    put_imm(16'd9, S_I1);
    put_imm(16'd4, S_I2);
    put(mv(8'h00, 8'h00));
    put(mv(S_O, 8'h02));
    load_and_reset();
    exec(c);
    rd(8'h01, v); chk("R6 difference wraps", v, 16'hFFFE);
    rd(8'h02, v); chk("R6 difference", v, 16'd5);
    rd(A_O, v);   chk("R6 adder untouched", v, 16'd0);
  endtask

  task automatic t_out_write();
    int c; logic [15:0] v;
    start_prog();
    put_imm(16'd1, A_I1);
    put_imm(16'd1, A_I2);
    put(mv(8'h00, 8'h00));
    put_imm(16'h7777, A_O);
    put_imm(16'h7777, S_O);
    load_and_reset();
    exec(c);
    rd(A_O, v); chk("R8 adder output not writable", v, 16'd2);
    rd(S_O, v); chk("R8 subtractor output not writable", v, 16'd0);
  endtask

  task automatic t_unmapped();
    int c; logic [15:0] v;
    start_prog();
    put_imm(16'hAAAA, 8'h02);
    put_imm(16'h1234, 8'h03);
    put_imm(16'h4321, A_I1);
    put(mv(8'h40, 8'h02));
    put(mv(A_I1, 8'h03));
    load_and_reset();
    exec(c);
    rd(8'h02, v); chk("R9 unmapped reads zero", v, 16'd0);
    rd(8'h03, v); chk("R9 input port reads zero", v, 16'd0);
    rd(S_I2, v);  chk("R9 trigger port reads zero", v, 16'd0);
  endtask

  task automatic t_halt_timing();
    int c; logic [15:0] v;
    start_prog();
    put_imm(16'd1, 8'h01);
    put(mv(8'h01, 8'h02));
    put(mv(8'h02, 8'h03));
    put(mv(8'h03, 8'h04));
    put(mv(8'h00, HLT));
    put_imm(16'h4444, 8'h07);
    load_and_reset();
    exec(c);
    chk("R12 one move per cycle", 16'(c), 16'd5);
    rd(8'h04, v); chk("R12 chain result", v, 16'd1);
    repeat (5) @(negedge clk);
    run = 1;
    repeat (5) @(negedge clk);
    run = 0;
    chk("R10 done stays set", 16'(done), 16'd1);
    rd(8'h07, v); chk("R10 nothing after halt", v, 16'd0);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R1 done low in reset", 16'(done), 16'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 done low after reset", 16'(done), 16'd0);
    rd(8'h04, v); chk("R1 register cleared", v, 16'd0);
    rd(8'h0F, v); chk("R1 last register cleared", v, 16'd0);
    rd(A_O, v);   chk("R1 adder output cleared", v, 16'd0);
  endtask

  task automatic t_run_low();
    int c; logic [15:0] v;
    start_prog();
    put_imm(16'h0099, 8'h01);
    load_and_reset();
    repeat (10) @(negedge clk);
    rd(8'h01, v); chk("R11 no execution while idle", v, 16'd0);
    chk("R11 no done while idle", 16'(done), 16'd0);
    exec(c);
    rd(8'h01, v); chk("R11 executes after run", v, 16'h0099);
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_move_imm();
    t_adder();
    t_sub();
    t_out_write();
    t_unmapped();
    t_halt_timing();
    t_reset();
    t_run_low();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule